// File: doc/BRIEF.md
# Serial-Loaded Eight-Channel DAC Code Register Bank

This block is the digital control core of an eight-channel digital-to-analog converter. A host writes it over a three-wire serial port made of a serial clock, a data line and an active-low select. While select is low, each rising serial clock edge shifts one data bit into an 11-bit input register. The word carries a 3-bit channel address in its upper bits and an 8-bit code in its lower bits. When select returns high, the address is decoded and only that channel's 8-bit code latch takes the new code.

All three serial lines are brought into the system clock domain through two-flop synchronizers. Serial clock edges and the select rising edge are detected in that domain, and the select edge becomes a one-cycle write strobe. An active-low asynchronous preset loads every latch with midscale (0x80). A synchronous system reset does the same. An active-low shutdown input is passed to the analog side as a registered, active-high indicator, and it never disturbs the stored codes.

Top module: `octal_dac_core`

## Requirements
- R1: Data is taken on rising edges of the serial clock, most significant bit first. The 11-bit word is {address[2:0], code[7:0]}, with the address in bits 10..8.
- R2: Serial clock edges that arrive while select is high do not change the input register.
- R3: On a select rising edge, the code is written to the channel the address names. Address value k drives code_o[8k+7:8k], so address 000 is the first channel and 111 is the eighth.
- R4: A write leaves every channel other than the addressed one unchanged, and no latch changes without a write strobe.
- R5: While preset_n is low, every latch reads 0x80 at once, without waiting for a clock edge. rst high also loads 0x80 into every latch at a clock edge.
- R6: When preset_n is low in the cycle that a write strobe occurs, every latch stays at 0x80.
- R7: shut_o equals the inverse of shdn_n, one system clock later. Shutdown has no effect on the latch values, either while it lasts or after it ends.
- R8: When a frame holds a number of clocks other than 11, the write uses the last 11 bits shifted in, including bits left over from earlier frames. The input register clears to zero on rst.
- R9: The write strobe lasts exactly one system clock cycle for each select rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset: clears the input register and presets the latches |
| preset_n | input | 1 | Asynchronous active-low preset of all latches to midscale |
| sclk | input | 1 | Serial clock, asynchronous to clk |
| sdi | input | 1 | Serial data |
| sel_n | input | 1 | Active-low select; its rising edge commits the word |
| shdn_n | input | 1 | Active-low shutdown request |
| code_o | output | 64 | Eight 8-bit channel codes; channel k sits at bits 8k+7..8k |
| shut_o | output | 1 | Registered shutdown indicator, high while shdn_n is low |

## Verification
The bench builds the block with its default parameters: a 3-bit address, 8-bit codes and a two-stage synchronizer. With these values the whole address space of eight channels is exercised, and both corner codes 0x00 and 0xFF can be written. The serial timing the bench drives keeps every serial edge within reach of the synchronizer. Random frames with lengths between 9 and 14 bits check the last-11-bits rule against a bench model of the input register. Directed cases cover clocks sent while select is high, a preset held across a write strobe, the asynchronous preset applied between clock edges, and shutdown toggling around writes.

// File: rtl/dacbank_pkg.sv
package dacbank_pkg;
  parameter int unsigned DAC_ADDR_W = 3;
  parameter int unsigned DAC_CODE_W = 8;
  parameter int unsigned DAC_SYNC_N = 2;

  function automatic logic [DAC_CODE_W-1:0] midscale_code();
    logic [DAC_CODE_W-1:0] v;
    v = '0;
    v[DAC_CODE_W-1] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/dacbank_sync.sv
module dacbank_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= RST_VAL;
    end else begin
      chain[0] <= d_i;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/dacbank_shifter.sv
module dacbank_shifter #(
  parameter int unsigned FRAME_W = 11
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sclk_s,
  input  logic               sdi_s,
  input  logic               sel_n_s,
  output logic [FRAME_W-1:0] word_o,
  output logic               wr_stb_o
);
  logic               sclk_d;
  logic               sel_d;
  logic [FRAME_W-1:0] shreg;
  logic               sclk_rise;

  assign sclk_rise = sclk_s & ~sclk_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d <= 1'b0;
      sel_d  <= 1'b1;
      shreg  <= '0;
    end else begin
      sclk_d <= sclk_s;
      sel_d  <= sel_n_s;
      if (sclk_rise && !sel_n_s) shreg <= {shreg[FRAME_W-2:0], sdi_s};
    end
  end

  assign word_o   = shreg;
  assign wr_stb_o = sel_n_s & ~sel_d;

  // R2: no shifting while the synchronized select is high
  a_r2_hold_when_deselected: assert property (@(posedge clk) disable iff (rst)
    sel_n_s |=> $stable(shreg));
  // R9: one-cycle strobe
  a_r9_single_strobe: assert property (@(posedge clk) disable iff (rst)
    wr_stb_o |=> !wr_stb_o);
endmodule

// File: rtl/dacbank_latches.sv
module dacbank_latches
  import dacbank_pkg::*;
#(
  parameter int unsigned ADDR_W = DAC_ADDR_W,
  parameter int unsigned CODE_W = DAC_CODE_W,
  localparam int unsigned NCH   = 1 << ADDR_W,
  localparam int unsigned FLAT_W = NCH * CODE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              preset_n,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CODE_W-1:0] wr_code,
  output logic [FLAT_W-1:0] code_o
);
  localparam logic [CODE_W-1:0] MID = {1'b1, {(CODE_W-1){1'b0}}};

  logic [CODE_W-1:0] mem [NCH];

  always_ff @(posedge clk or negedge preset_n) begin
    if (!preset_n) begin
      for (int c = 0; c < NCH; c++) mem[c] <= MID;
    end else if (rst) begin
      for (int c = 0; c < NCH; c++) mem[c] <= MID;
    end else if (wr_stb) begin
      mem[wr_addr] <= wr_code;
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_flat
    assign code_o[g*CODE_W +: CODE_W] = mem[g];
  end

  // R4: no change without a strobe
  a_r4_stable_without_write: assert property (@(posedge clk) disable iff (rst || !preset_n)
    !$past(wr_stb) |-> $stable(code_o));
  // R5 and R6: held preset keeps every channel at midscale, even over a strobe
  a_r5_preset_midscale: assert property (@(posedge clk) disable iff (rst)
    (!preset_n && $past(!preset_n)) |-> (code_o == {NCH{MID}}));
  // R3: a strobe lands its code in the addressed channel
  a_r3_addressed_write: assert property (@(posedge clk) disable iff (rst || !preset_n)
    wr_stb |=> (mem[$past(wr_addr)] == $past(wr_code)));
endmodule

// File: rtl/octal_dac_core.sv
module octal_dac_core
  import dacbank_pkg::*;
#(
  parameter int unsigned ADDR_W = DAC_ADDR_W,
  parameter int unsigned CODE_W = DAC_CODE_W,
  parameter int unsigned SYNC_N = DAC_SYNC_N,
  localparam int unsigned NCH     = 1 << ADDR_W,
  localparam int unsigned FRAME_W = ADDR_W + CODE_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  preset_n,
  input  logic                  sclk,
  input  logic                  sdi,
  input  logic                  sel_n,
  input  logic                  shdn_n,
  output logic [NCH*CODE_W-1:0] code_o,
  output logic                  shut_o
);
  logic [2:0]         sync_q;
  logic [FRAME_W-1:0] word;
  logic               wr_stb;

  dacbank_sync #(.W(3), .STAGES(SYNC_N), .RST_VAL(3'b100)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i ({sel_n, sdi, sclk}),
    .q_o (sync_q)
  );

  dacbank_shifter #(.FRAME_W(FRAME_W)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .sclk_s   (sync_q[0]),
    .sdi_s    (sync_q[1]),
    .sel_n_s  (sync_q[2]),
    .word_o   (word),
    .wr_stb_o (wr_stb)
  );

  dacbank_latches #(.ADDR_W(ADDR_W), .CODE_W(CODE_W)) u_lat (
    .clk      (clk),
    .rst      (rst),
    .preset_n (preset_n),
    .wr_stb   (wr_stb),
    .wr_addr  (word[FRAME_W-1 -: ADDR_W]),
    .wr_code  (word[CODE_W-1:0]),
    .code_o   (code_o)
  );

  always_ff @(posedge clk) begin
    if (rst) shut_o <= 1'b0;
    else     shut_o <= ~shdn_n;
  end

  // R7: indicator follows the inverted request one cycle later
  a_r7_shut_mirror: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (shut_o == !$past(shdn_n)));
endmodule

// File: tb/octal_dac_core_tb.sv
module octal_dac_core_tb;
  localparam int HALF = 4;

  logic clk = 0;
  logic rst = 1, preset_n = 1, sclk = 0, sdi = 0, sel_n = 1, shdn_n = 1;
  logic [63:0] code_o;
  logic shut_o;

  logic [7:0]  exp_code [8];
  logic [10:0] exp_sr;
  int errs = 0, checks = 0;
  bit  done = 0;

  always #2 clk = ~clk;

  octal_dac_core u_dut (
    .clk(clk), .rst(rst), .preset_n(preset_n), .sclk(sclk), .sdi(sdi),
    .sel_n(sel_n), .shdn_n(shdn_n), .code_o(code_o), .shut_o(shut_o));

  function automatic logic [10:0] mk_word(input logic [2:0] a, input logic [7:0] c);
    return {a, c};
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_all(input string tag);
    for (int k = 0; k < 8; k++) begin
      checks++;
      if (code_o[8*k +: 8] !== exp_code[k]) begin
        errs++;
        $display("FAIL %s ch%0d actual=%h expected=%h", tag, k, code_o[8*k +: 8], exp_code[k]);
      end
    end
  endtask

  task automatic check_bit(input string tag, input logic act, input logic expv);
    checks++;
    if (act !== expv) begin
      errs++;
      $display("FAIL %s actual=%b expected=%b", tag, act, expv);
    end
  endtask

  task automatic clock_bit(input logic b, input bit model);
    sdi = b; cyc(HALF);
    sclk = 1; cyc(HALF);
    sclk = 0;
    if (model) exp_sr = {exp_sr[9:0], b};
  endtask

  // send the low n bits of v, MSB first; with_write models the commit
  task automatic send_frame(input logic [15:0] v, input int n, input bit with_write);
    sel_n = 0; cyc(HALF);
    for (int i = n - 1; i >= 0; i--) clock_bit(v[i], 1);
    cyc(HALF);
    sel_n = 1; cyc(10);
    if (with_write) exp_code[exp_sr[10:8]] = exp_sr[7:0];
  endtask

  task automatic all_mid();
    for (int k = 0; k < 8; k++) exp_code[k] = 8'h80;
  endtask

  initial begin
    void'($urandom(32'h5EED1234));
    exp_sr = '0;
    all_mid();
    cyc(4);
    rst = 0;
    cyc(4);
    check_all("R5 reset state midscale");
    check_bit("R7 shut idle", shut_o, 1'b0);

    // R1 R3 R4: one write to every address with distinct codes
    for (int a = 0; a < 8; a++) begin
      send_frame({5'd0, mk_word(3'(a), 8'(8'h11 * a + 8'h03))}, 11, 1);
      check_all("R3 R4 addressed write");
    end
    send_frame({5'd0, mk_word(3'd0, 8'h00)}, 11, 1);
    send_frame({5'd0, mk_word(3'd7, 8'hFF)}, 11, 1);
    check_all("R1 corner codes");

    // R2: clocks with select high are ignored; an empty frame then rewrites exp_sr
    for (int i = 0; i < 5; i++) clock_bit(1'b1, 0);
    check_all("R2 no write from deselected clocks");
    send_frame(16'h0, 0, 1);
    check_all("R2 R8 empty frame reuses register");

    // R7: shutdown keeps codes
    shdn_n = 0; cyc(2);
    check_bit("R7 shut asserted", shut_o, 1'b1);
    send_frame({5'd0, mk_word(3'd2, 8'h5A)}, 11, 1);
    check_all("R7 writes during shutdown");
    shdn_n = 1; cyc(2);
    check_bit("R7 shut released", shut_o, 1'b0);
    check_all("R7 codes kept after shutdown");

    // R6: preset held across a strobe
    preset_n = 0;
    all_mid();
    send_frame({5'd0, mk_word(3'd4, 8'h3C)}, 11, 0);
    check_all("R6 preset beats strobe");
    preset_n = 1; cyc(2);

    // R5: asynchronous preset between edges
    send_frame({5'd0, mk_word(3'd1, 8'hC3)}, 11, 1);
    check_all("R3 write before async preset");
    #1 preset_n = 0;
    #0.5;
    all_mid();
    check_all("R5 async preset without edge");
    cyc(2); preset_n = 1; cyc(2);

    // R8 R1: random frames, lengths 9..14
    for (int f = 0; f < 60; f++) begin
      logic [15:0] v;
      int n;
      v = 16'($urandom);
      n = (f % 3 == 0) ? 9 + int'($urandom % 6) : 11;
      send_frame(v, n, 1);
      check_all("R8 random frame");
    end

    // R5: synchronous rst also presets
    rst = 1; cyc(2); rst = 0; cyc(2);
    all_mid(); exp_sr = '0;
    check_all("R5 rst midscale");
    send_frame(16'h0, 0, 1);
    check_all("R8 register cleared by rst");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule